// File: doc/BRIEF.md
# Symbol-Granular Header Prepender

This block places a fixed-length header in front of every data block that arrives on a framed stream. The stream carries valid/ready handshaking, start-of-packet and end-of-packet markers, and an empty count for the last word. The output is a single frame. It starts with the header and continues with the payload. The seam between header and payload lies on a symbol boundary, not on a word boundary, so a header whose length is not a whole number of words is followed directly by the first payload symbols in the same word.

The header is presented as a flat vector. Its first symbol sits in the most significant bits. The block captures the vector when the first word of a frame is offered, so the producer may change it once that word has been taken. The block emits the whole header words first, with the input stalled. It then re-packs each incoming word behind the header remainder carried over from the previous word. When the carried symbols do not fit into the last input word, the block emits one extra word. The empty count of the final output word is recomputed for the combined length. With the symbol width equal to the data width there is no remainder, the payload passes through word for word, and empty stays zero.

Top module: `hdr_symcat`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid and in_ready are low.
- R2: The first accepted beat of every output frame has out_sop high and carries the first DATA_W bits of the header vector, with header symbol 0 at bits [DATA_W-1 -: SYM_W].
- R3: Within a word, symbols are ordered from the most significant end. Payload symbol 0 directly follows the last header symbol, with no gap symbols, and payload order is preserved across words.
- R4: out_eop is high only on the last word of the combined frame. Its out_empty equals the number of unused low-order symbols: (NSYM - (HDR_SYMS + L) mod NSYM) mod NSYM for L payload symbols.
- R5: out_empty is zero on every valid beat without out_eop, and out_sop and out_eop are low whenever out_valid is low.
- R6: When the input end word holds fewer empty symbols than the header remainder, one extra output word is emitted after it, and that extra word carries out_eop and the recomputed empty count.
- R7: The header is captured when a start-of-packet word is first offered. Changes on hdr_in after that word has been accepted do not alter the header symbols of that frame.
- R8: in_ready stays low until all whole header words of the current frame have been accepted at the output.
- R9: While out_valid is high and out_ready is low, out_valid, out_data, out_sop, out_eop and out_empty hold their values.
- R10: No symbol is lost or duplicated with bursty input valid, random output ready and zero gaps between frames, and an output frame's out_sop beat comes only after the previous frame's out_eop beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_in | input | HDR_SYMS*SYM_W | Header vector, symbol 0 in the MSBs |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_sop | input | 1 | First word of an input data block |
| in_eop | input | 1 | Last word of an input data block |
| in_empty | input | EMPTY_W | Unused low symbols in the input end word |
| in_data | input | DATA_W | Input payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sop | output | 1 | First word of the combined frame |
| out_eop | output | 1 | Last word of the combined frame |
| out_empty | output | EMPTY_W | Unused low symbols in the output end word |
| out_data | output | DATA_W | Output word |

## Verification
The checker relies on the upstream side behaving as a well-formed stream. A word that has been offered stays unchanged until it is accepted. The first word of each block carries in_sop, in_empty is nonzero only on the end word, and every block holds at least one payload symbol. The bench source follows these rules: once it raises in_valid it keeps the current word stable until the handshake, and it takes every word from a queue of frames that was built to be well-formed. It varies in_valid gaps and out_ready independently, and the payload lengths cover every residue modulo the word size, both with and without the extra end word.

// File: rtl/hdr_symcat_pkg.sv
package hdr_symcat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_TAIL
  } cat_state_e;
endpackage

// File: rtl/hdr_symcat_shift.sv
// Re-packs one input word behind SHIFT_SYMS carried symbols (top-aligned).
module hdr_symcat_shift #(
  parameter int DATA_W     = 32,
  parameter int SYM_W      = 8,
  parameter int SHIFT_SYMS = 2
) (
  input  logic [DATA_W-1:0] carry_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] merged_o,
  output logic [DATA_W-1:0] spill_o
);
  localparam int SH_BITS   = SHIFT_SYMS * SYM_W;
  localparam int KEEP_BITS = DATA_W - SH_BITS;

  generate
    if (SHIFT_SYMS == 0) begin : g_aligned
      // Header ends on a word boundary: payload passes straight through.
      logic unused_carry;
      assign unused_carry = ^carry_i;
      assign merged_o     = data_i;
      assign spill_o      = '0;
    end else begin : g_shifted
      logic [DATA_W-1:0] top_mask;
      assign top_mask = ~({DATA_W{1'b1}} >> SH_BITS);
      assign merged_o = (carry_i & top_mask) | (data_i >> SH_BITS);
      assign spill_o  = data_i << KEEP_BITS;
    end
  endgenerate
endmodule

// File: rtl/hdr_symcat_hold.sv
// Captures the header vector and serves it as whole words plus a remainder.
module hdr_symcat_hold #(
  parameter int DATA_W   = 32,
  parameter int SYM_W    = 8,
  parameter int HDR_SYMS = 6,
  parameter int IDX_W    = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [HDR_SYMS*SYM_W-1:0] hdr_i,
  input  logic [IDX_W-1:0]          sel_i,
  output logic [DATA_W-1:0]         word_o,
  output logic [DATA_W-1:0]         rem_o
);
  localparam int NSYM     = DATA_W / SYM_W;
  localparam int HDR_W    = HDR_SYMS * SYM_W;
  localparam int HDR_FULL = HDR_SYMS / NSYM;
  localparam int PAD_W    = HDR_W + DATA_W;

  logic [HDR_W-1:0] hdr_q, hdr_d;
  logic [PAD_W-1:0] pad;

  always_comb hdr_d = load_i ? hdr_i : hdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else        hdr_q <= hdr_d;
  end

  // Zero padding keeps the remainder slice in range for any header length.
  assign pad    = {hdr_q, {DATA_W{1'b0}}};
  assign word_o = pad[PAD_W-1 - int'(sel_i)*DATA_W -: DATA_W];
  assign rem_o  = pad[PAD_W-1 - HDR_FULL*DATA_W -: DATA_W];
endmodule

// File: rtl/hdr_symcat.sv
module hdr_symcat
  import hdr_symcat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SYM_W    = 8,
  parameter int HDR_SYMS = 6,
  localparam int NSYM    = DATA_W / SYM_W,
  localparam int EMPTY_W = (NSYM > 1) ? $clog2(NSYM) : 1,
  localparam int HDR_W   = HDR_SYMS * SYM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HDR_W-1:0]   hdr_in,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_sop,
  output logic               out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic [DATA_W-1:0]  out_data
);
  localparam int HDR_FULL = HDR_SYMS / NSYM;
  localparam int HDR_REM  = HDR_SYMS % NSYM;
  localparam int IDX_W    = (HDR_FULL > 1) ? $clog2(HDR_FULL) : 1;

  cat_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  carry_q, carry_d;
  logic [EMPTY_W-1:0] tail_emp_q, tail_emp_d;
  logic               first_q, first_d;
  logic               ov_q, ov_d, osop_q, osop_d, oeop_q, oeop_d;
  logic [EMPTY_W-1:0] oemp_q, oemp_d;
  logic [DATA_W-1:0]  odat_q, odat_d;

  logic               adv, load_hdr;
  logic [DATA_W-1:0]  hdr_word, hdr_rem, merged, spill;

  hdr_symcat_hold #(
    .DATA_W(DATA_W), .SYM_W(SYM_W), .HDR_SYMS(HDR_SYMS), .IDX_W(IDX_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load_hdr), .hdr_i(hdr_in),
    .sel_i(idx_q), .word_o(hdr_word), .rem_o(hdr_rem)
  );

  hdr_symcat_shift #(
    .DATA_W(DATA_W), .SYM_W(SYM_W), .SHIFT_SYMS(HDR_REM)
  ) u_shift (
    .carry_i(carry_q), .data_i(in_data), .merged_o(merged), .spill_o(spill)
  );

  // The output register may load when it is empty or being drained.
  assign adv = !ov_q || out_ready;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    carry_d    = carry_q;
    tail_emp_d = tail_emp_q;
    first_d    = first_q;
    load_hdr   = 1'b0;
    in_ready   = 1'b0;
    ov_d       = ov_q;
    osop_d     = osop_q;
    oeop_d     = oeop_q;
    oemp_d     = oemp_q;
    odat_d     = odat_q;
    if (adv) begin
      ov_d   = 1'b0;
      osop_d = 1'b0;
      oeop_d = 1'b0;
      oemp_d = '0;
    end
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid && in_sop) begin
          load_hdr = 1'b1;
          idx_d    = '0;
          first_d  = 1'b1;
          state_d  = ST_HDR;
        end
      end
      ST_HDR: begin
        if (HDR_FULL == 0) begin
          carry_d = hdr_rem;
          state_d = ST_DATA;
        end else if (adv) begin
          ov_d    = 1'b1;
          osop_d  = first_q;
          odat_d  = hdr_word;
          first_d = 1'b0;
          if (int'(idx_q) == HDR_FULL - 1) begin
            carry_d = hdr_rem;
            state_d = ST_DATA;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        in_ready = adv;
        if (adv && in_valid) begin
          ov_d    = 1'b1;
          osop_d  = first_q;
          odat_d  = merged;
          first_d = 1'b0;
          carry_d = spill;
          if (in_eop) begin
            if (int'(in_empty) >= HDR_REM) begin
              oeop_d  = 1'b1;
              oemp_d  = in_empty - EMPTY_W'(HDR_REM);
              state_d = ST_IDLE;
            end else begin
              tail_emp_d = EMPTY_W'(NSYM - HDR_REM) + in_empty;
              state_d    = ST_TAIL;
            end
          end
        end
      end
      ST_TAIL: begin
        if (adv) begin
          ov_d    = 1'b1;
          oeop_d  = 1'b1;
          oemp_d  = tail_emp_q;
          odat_d  = carry_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      carry_q    <= '0;
      tail_emp_q <= '0;
      first_q    <= 1'b0;
      ov_q       <= 1'b0;
      osop_q     <= 1'b0;
      oeop_q     <= 1'b0;
      oemp_q     <= '0;
      odat_q     <= '0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      carry_q    <= carry_d;
      tail_emp_q <= tail_emp_d;
      first_q    <= first_d;
      ov_q       <= ov_d;
      osop_q     <= osop_d;
      oeop_q     <= oeop_d;
      oemp_q     <= oemp_d;
      odat_q     <= odat_d;
    end
  end

  assign out_valid = ov_q;
  assign out_sop   = osop_q;
  assign out_eop   = oeop_q;
  assign out_empty = oemp_q;
  assign out_data  = odat_q;
endmodule

// File: rtl/hdr_symcat_chk.sv
module hdr_symcat_chk #(
  parameter int DATA_W   = 32,
  parameter int SYM_W    = 8,
  parameter int HDR_SYMS = 6,
  localparam int NSYM    = DATA_W / SYM_W,
  localparam int EMPTY_W = (NSYM > 1) ? $clog2(NSYM) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_sop,
  input logic               in_eop,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_sop,
  input logic               out_eop,
  input logic [EMPTY_W-1:0] out_empty,
  input logic [DATA_W-1:0]  out_data
);
  localparam int HDR_FULL = HDR_SYMS / NSYM;

  logic       in_frame, out_frame;
  logic [7:0] ob_cnt;
  logic       in_acc, out_acc;

  assign in_acc  = in_valid && in_ready;
  assign out_acc = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      out_frame <= 1'b0;
      ob_cnt    <= '0;
    end else begin
      if (in_acc) in_frame <= !in_eop;
      if (out_acc) begin
        out_frame <= !out_eop;
        if (out_eop)              ob_cnt <= '0;
        else if (ob_cnt != 8'hFF) ob_cnt <= ob_cnt + 8'd1;
      end
    end
  end

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                && $stable(out_eop) && $stable(out_empty));

  a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_sop && !out_eop);

  a_r5_empty_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_empty == '0);

  a_r8_input_after_header: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc |-> int'(ob_cnt) + int'(out_acc) >= HDR_FULL);

  a_r10_sop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !out_frame);

  a_r10_body_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> out_frame);

  a_r4_end_follows_input_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_acc && out_eop |-> !in_frame);

  // in_sop is part of the input contract; referenced so the port is used.
  a_r2_sop_starts_block: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc && in_sop |-> !in_frame);
endmodule

bind hdr_symcat hdr_symcat_chk #(
  .DATA_W(DATA_W), .SYM_W(SYM_W), .HDR_SYMS(HDR_SYMS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
  .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
  .out_empty(out_empty), .out_data(out_data)
);

// File: tb/hdr_symcat_tb.sv
module hdr_symcat_tb;
  localparam int DATA_W   = 32;
  localparam int SYM_W    = 8;
  localparam int HDR_SYMS = 6;
  localparam int NSYM     = DATA_W / SYM_W;
  localparam int EMPTY_W  = 2;
  localparam int HDR_W    = HDR_SYMS * SYM_W;
  localparam int HDR_FULL = HDR_SYMS / NSYM;
  localparam int LIMIT    = 100000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n;
  logic [HDR_W-1:0]   hdr_in;
  logic               in_valid, in_ready, in_sop, in_eop;
  logic [EMPTY_W-1:0] in_empty;
  logic [DATA_W-1:0]  in_data;
  logic               out_valid, out_ready, out_sop, out_eop;
  logic [EMPTY_W-1:0] out_empty;
  logic [DATA_W-1:0]  out_data;

  hdr_symcat #(.DATA_W(DATA_W), .SYM_W(SYM_W), .HDR_SYMS(HDR_SYMS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_in(hdr_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_empty(out_empty), .out_data(out_data)
  );

  typedef struct {
    logic [DATA_W-1:0] d;
    logic              sop;
    logic              eop;
    int                emp;
    logic [HDR_W-1:0]  h;
    logic              tail;
    logic              has_hdr;
  } beat_t;

  beat_t in_q[$];
  beat_t exp_q[$];
  int n_run = 0, n_fail = 0;
  int frames_sent = 0, frames_seen = 0;
  int mode = 0, cyc = 0;
  bit running = 0, acc_in = 0;
  bit stall_prev = 0, o_started = 0;
  int o_beats = 0;
  logic [DATA_W-1:0]  sv_d;
  logic               sv_sop, sv_eop;
  logic [EMPTY_W-1:0] sv_emp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference: header symbols then payload symbols, packed MSB first.
  task automatic add_frame(input int len);
    logic [HDR_W-1:0] h;
    logic [SYM_W-1:0] all[$];
    logic [SYM_W-1:0] pl[$];
    int tot, n_in, n_out;
    h = HDR_W'({$urandom(), $urandom()});
    for (int j = 0; j < HDR_SYMS; j++) all.push_back(h[HDR_W-1-j*SYM_W -: SYM_W]);
    for (int j = 0; j < len; j++) begin
      logic [SYM_W-1:0] b;
      b = SYM_W'($urandom());
      pl.push_back(b);
      all.push_back(b);
    end
    tot   = HDR_SYMS + len;
    n_in  = (len + NSYM - 1) / NSYM;
    n_out = (tot + NSYM - 1) / NSYM;
    for (int w = 0; w < len; w += NSYM) begin
      beat_t bt;
      bt.d = '0;
      for (int k = 0; k < NSYM; k++)
        if (w + k < len) bt.d[DATA_W-1-k*SYM_W -: SYM_W] = pl[w+k];
      bt.sop = (w == 0);
      bt.eop = (w + NSYM >= len);
      bt.emp = bt.eop ? (w + NSYM - len) : 0;
      bt.h = h; bt.tail = 1'b0; bt.has_hdr = 1'b0;
      in_q.push_back(bt);
    end
    for (int w = 0; w < tot; w += NSYM) begin
      beat_t bt;
      bt.d = '0;
      for (int k = 0; k < NSYM; k++)
        if (w + k < tot) bt.d[DATA_W-1-k*SYM_W -: SYM_W] = all[w+k];
      bt.sop = (w == 0);
      bt.eop = (w + NSYM >= tot);
      bt.emp = bt.eop ? (w + NSYM - tot) : 0;
      bt.h = h;
      bt.tail = bt.eop && (n_out > HDR_FULL + n_in);
      bt.has_hdr = (w < HDR_SYMS);
      exp_q.push_back(bt);
    end
    frames_sent++;
  endtask

  // Driver: updates inputs just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (running) begin
      if (acc_in) begin
        void'(in_q.pop_front());
        hdr_in = HDR_W'({$urandom(), $urandom()});
      end
      if (!(in_valid && !acc_in)) begin
        if (in_q.size() > 0 && (mode != 1 || ($urandom() % 3) != 0)) begin
          in_valid = 1'b1;
          in_data  = in_q[0].d;
          in_sop   = in_q[0].sop;
          in_eop   = in_q[0].eop;
          in_empty = EMPTY_W'(in_q[0].emp);
          if (in_q[0].sop) hdr_in = in_q[0].h;
        end else begin
          in_valid = 1'b0;
          in_sop   = 1'b0;
          in_eop   = 1'b0;
          in_empty = '0;
        end
      end
      out_ready = (mode == 0) ? 1'b1 : (($urandom() % 4) != 0);
    end
  end

  // Monitor: compares against the reference on every falling edge.
  always @(negedge clk) begin
    cyc++;
    if (running) begin
      acc_in = in_valid && in_ready;
      if (!out_valid)
        chk(!out_sop && !out_eop, "R5", "sop/eop while idle", {out_sop, out_eop}, 0);
      if (stall_prev)
        chk(out_valid && out_data == sv_d && out_sop == sv_sop && out_eop == sv_eop
            && out_empty == sv_emp, "R9", "held beat", out_data, sv_d);
      stall_prev = out_valid && !out_ready;
      sv_d = out_data; sv_sop = out_sop; sv_eop = out_eop; sv_emp = out_empty;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected output beat", out_data, 0);
        end else begin
          beat_t e;
          string tag;
          e = exp_q.pop_front();
          if (e.tail)         tag = "R6";
          else if (e.sop)     tag = "R2 R7";
          else if (e.has_hdr) tag = "R3 R7";
          else                tag = "R3";
          chk(out_data == e.d, tag, "data", out_data, e.d);
          chk(out_sop == e.sop, "R2", "sop", out_sop, e.sop);
          chk(out_eop == e.eop, e.tail ? "R6" : "R4", "eop", out_eop, e.eop);
          chk(int'(out_empty) == e.emp, e.eop ? "R4" : "R5", "empty", out_empty, e.emp);
          if (e.sop) begin o_started = 1; o_beats = 1; end
          else o_beats++;
          if (e.eop) begin o_started = 0; frames_seen++; end
        end
      end
      if (acc_in && in_sop)
        chk(o_started && o_beats >= HDR_FULL, "R8", "input taken before header out",
            o_beats, HDR_FULL);
    end
  end

  task automatic run_phase(input int m);
    mode = m;
    wait ((in_q.size() == 0 && exp_q.size() == 0) || cyc > LIMIT);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; hdr_in = '0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_empty = '0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_ready, "R1", "during reset", {out_valid, in_ready}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R1", "after reset", {out_valid, in_ready}, 0);
    running = 1;
    // Zero gaps, full throughput, every length residue (R6 when L mod 4 is 0 or 3).
    for (int l = 1; l <= 12; l++) add_frame(l);
    run_phase(0);
    // Bursty valid and random ready (R9, R10).
    for (int f = 0; f < 30; f++) add_frame(1 + int'($urandom() % 20));
    run_phase(1);
    // Continuous valid with back-pressure.
    for (int l = 1; l <= 10; l++) add_frame(l);
    run_phase(2);
    if (cyc > LIMIT) begin
      n_run++; n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
    end
    chk(frames_seen == frames_sent, "R10", "frame count", frames_seen, frames_sent);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule